// File: doc/BRIEF.md
# Ethernet Controller Interrupt Status Unit

This block collects the interrupt sources of a small Ethernet MAC into one status register, gives software a way to acknowledge them, and drives a single maskable interrupt line. Some status bits are latched from event pulses and stay set until software clears them. Others follow the not-empty flag of a completion FIFO directly. The allocation bit is managed by the page allocator itself. The status-engine bit is cleared by actions that happen in other registers.

Software reads the status register and clears latched bits by writing to the same address, which acts as the acknowledge register. A mask register chooses which status bits can raise the interrupt line. Acknowledging the transmit-complete bit produces a one-cycle pop of the head of the transmit completion FIFO. The register port is a plain synchronous write with a combinational read. The pop is a plain pulse with no handshake, because the FIFO always takes it.

Status layout, low to high: bit 0 receive pending, bit 1 transmit complete, bit 2 transmit queue empty, bit 3 allocation done, bit 4 receive overrun, bit 5 status engine. Bits 7:6 read as zero. Address 0 is status on read and acknowledge on write. Address 1 is the mask register. All other addresses read as zero.

Top module: `eth_irq_status`

## Requirements
- R1: After reset all latched status bits and the mask register are 0, so the interrupt line is low.
- R2: Status bit 4 (receive overrun) is set one cycle after any of the three receive-abort pulses (no buffer, frame too long, discard). It holds until a write to address 0 with bit 4 set.
- R3: Status bit 3 (allocation done) is set one cycle after an allocation-success pulse. It is cleared one cycle after an allocation request or an allocation-failure pulse. Acknowledge writes do not affect it.
- R4: Status bit 2 (transmit queue empty) is set one cycle after the queue-empty pulse. It holds until a write to address 0 with bit 2 set.
- R5: Status bit 1 equals the inverse of the transmit completion FIFO empty flag. A write to address 0 with bit 1 set, while that FIFO is not empty, asserts the pop output for exactly that write cycle.
- R6: Status bit 0 equals the inverse of the receive FIFO empty flag. Acknowledge writes do not affect it.
- R7: A link-change event sets status bit 5. That cause is cleared one cycle after the link-error enable input falls from 1 to 0.
- R8: A counter-rollover event sets status bit 5. That cause is cleared one cycle after a statistics-counter read pulse.
- R9: A fatal transmit error event sets status bit 5. That cause is cleared one cycle after a transmit-enable set pulse. A clearing action for a different cause has no effect, and acknowledge writes do not affect bit 5.
- R10: The interrupt line is the OR of (status AND mask). The mask is written and read at address 1, with bits 7:6 reading as 0.
- R11: Acknowledge bits written as 0 leave their status bits unchanged. If a set event and an acknowledge of the same latched bit happen in the same cycle, the bit stays set.
- R12: Status bits 7:6 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 status/acknowledge, 1 mask) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| rx_abort_nomem | input | 1 | Pulse: receive aborted, no buffer memory |
| rx_abort_long | input | 1 | Pulse: receive aborted, frame over 2048 bytes |
| rx_abort_discard | input | 1 | Pulse: receive aborted by discard control |
| alloc_req | input | 1 | Pulse: allocator starts a new request |
| alloc_ok | input | 1 | Pulse: transmit page allocation succeeded |
| alloc_fail | input | 1 | Pulse: transmit page allocation failed |
| txq_empty_evt | input | 1 | Pulse: transmit queue became empty |
| txc_fifo_empty | input | 1 | Transmit completion FIFO empty flag |
| txc_pop | output | 1 | One-cycle pop of the completion FIFO head |
| rxc_fifo_empty | input | 1 | Receive FIFO empty flag |
| link_evt | input | 1 | Pulse: link-OK transition |
| cnt_roll_evt | input | 1 | Pulse: statistics counter rollover |
| tx_fatal_evt | input | 1 | Pulse: fatal transmit error (SQE, lost carrier, late collision, 16 collisions) |
| link_err_en | input | 1 | Link-error enable control bit (level) |
| cnt_reg_rd | input | 1 | Pulse: statistics counter register read |
| tx_en_set | input | 1 | Pulse: transmit enable bit written to 1 |
| irq | output | 1 | Interrupt output |

## Verification
The bench builds the block with its default 8-bit register width and 2-bit address. At that width all six status bits and the two zero pad bits appear on the read port. Addresses 2 and 3 are unmapped and read as zero. The 8-bit data also allows acknowledge patterns that set every bit except one, which show that a zero bit leaves its status alone. With three engine causes, each clearing action can be applied while the other two causes are pending, so the bench can show that only the matching action clears bit 5.

// File: rtl/eth_irq_pkg.sv
package eth_irq_pkg;
  localparam int REG_W     = 8;
  localparam int ADDR_W    = 2;
  localparam int STAT_BITS = 6;
  // status bit positions (software decodes these)
  localparam int B_RCV   = 0;
  localparam int B_TX    = 1;
  localparam int B_TXE   = 2;
  localparam int B_ALLOC = 3;
  localparam int B_RXOVR = 4;
  localparam int B_ENG   = 5;
  // engine cause slots
  localparam int NUM_CAUSE = 3;
  localparam int C_LINK    = 0;
  localparam int C_CNT     = 1;
  localparam int C_TXF     = 2;
  // sticky slots in the shared latch bank
  localparam int NUM_STICKY = 3;
  localparam int S_RXOVR    = 0;
  localparam int S_TXE      = 1;
  localparam int S_ALLOC    = 2;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] A_MASK = 2'd1;
endpackage

// File: rtl/eth_irq_latch.sv
// Bank of set/clear flops; a set in the same cycle as a clear wins.
module eth_irq_latch #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/eth_irq_engine.sv
// Status-engine bit: one flop per cause, each cleared by its own action.
module eth_irq_engine
  import eth_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic link_evt,
  input  logic cnt_roll_evt,
  input  logic tx_fatal_evt,
  input  logic link_err_en,
  input  logic cnt_reg_rd,
  input  logic tx_en_set,
  output logic eng_bit
);
  logic                 link_en_q;
  logic                 link_en_fall;
  logic [NUM_CAUSE-1:0] cause_set, cause_clr, cause_q;

  always_ff @(posedge clk) begin
    if (!rst_n) link_en_q <= 1'b0;
    else        link_en_q <= link_err_en;
  end
  assign link_en_fall = link_en_q & ~link_err_en;

  always_comb begin
    cause_set        = '0;
    cause_clr        = '0;
    cause_set[C_LINK] = link_evt;
    cause_set[C_CNT]  = cnt_roll_evt;
    cause_set[C_TXF]  = tx_fatal_evt;
    cause_clr[C_LINK] = link_en_fall;
    cause_clr[C_CNT]  = cnt_reg_rd;
    cause_clr[C_TXF]  = tx_en_set;
  end

  eth_irq_latch #(.N(NUM_CAUSE)) u_cause (
    .clk(clk), .rst_n(rst_n), .set(cause_set), .clr(cause_clr), .q(cause_q)
  );

  assign eng_bit = |cause_q;
endmodule

// File: rtl/eth_irq_regs.sv
// Register port: acknowledge decode, mask register, read mux.
module eth_irq_regs
  import eth_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  input  logic [STAT_BITS-1:0] status,
  output logic [REG_W-1:0]     reg_rdata,
  output logic [STAT_BITS-1:0] mask_q,
  output logic [STAT_BITS-1:0] ack
);
  localparam int PAD_W = REG_W - STAT_BITS;

  logic wdata_unused;
  assign wdata_unused = ^reg_wdata[REG_W-1:STAT_BITS];

  assign ack = (reg_wr && reg_addr == A_STAT) ? reg_wdata[STAT_BITS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)                           mask_q <= '0;
    else if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata[STAT_BITS-1:0];
  end

  always_comb begin
    unique case (reg_addr)
      A_STAT:  reg_rdata = {{PAD_W{1'b0}}, status};
      A_MASK:  reg_rdata = {{PAD_W{1'b0}}, mask_q};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/eth_irq_status.sv
module eth_irq_status
  import eth_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              rx_abort_nomem,
  input  logic              rx_abort_long,
  input  logic              rx_abort_discard,
  input  logic              alloc_req,
  input  logic              alloc_ok,
  input  logic              alloc_fail,
  input  logic              txq_empty_evt,
  input  logic              txc_fifo_empty,
  output logic              txc_pop,
  input  logic              rxc_fifo_empty,
  input  logic              link_evt,
  input  logic              cnt_roll_evt,
  input  logic              tx_fatal_evt,
  input  logic              link_err_en,
  input  logic              cnt_reg_rd,
  input  logic              tx_en_set,
  output logic              irq
);
  logic [STAT_BITS-1:0]  status_w, mask_q, ack;
  logic [NUM_STICKY-1:0] stk_set, stk_clr, stk_q;
  logic                  eng_bit;

  always_comb begin
    stk_set          = '0;
    stk_clr          = '0;
    stk_set[S_RXOVR] = rx_abort_nomem | rx_abort_long | rx_abort_discard;
    stk_clr[S_RXOVR] = ack[B_RXOVR];
    stk_set[S_TXE]   = txq_empty_evt;
    stk_clr[S_TXE]   = ack[B_TXE];
    stk_set[S_ALLOC] = alloc_ok;
    stk_clr[S_ALLOC] = alloc_req | alloc_fail;
  end

  eth_irq_latch #(.N(NUM_STICKY)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set(stk_set), .clr(stk_clr), .q(stk_q)
  );

  eth_irq_engine u_engine (
    .clk(clk), .rst_n(rst_n),
    .link_evt(link_evt), .cnt_roll_evt(cnt_roll_evt), .tx_fatal_evt(tx_fatal_evt),
    .link_err_en(link_err_en), .cnt_reg_rd(cnt_reg_rd), .tx_en_set(tx_en_set),
    .eng_bit(eng_bit)
  );

  always_comb begin
    status_w          = '0;
    status_w[B_RCV]   = ~rxc_fifo_empty;
    status_w[B_TX]    = ~txc_fifo_empty;
    status_w[B_TXE]   = stk_q[S_TXE];
    status_w[B_ALLOC] = stk_q[S_ALLOC];
    status_w[B_RXOVR] = stk_q[S_RXOVR];
    status_w[B_ENG]   = eng_bit;
  end

  eth_irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .status(status_w), .reg_rdata(reg_rdata),
    .mask_q(mask_q), .ack(ack)
  );

  assign txc_pop = ack[B_TX] & ~txc_fifo_empty;
  assign irq     = |(status_w & mask_q);
endmodule

// File: rtl/eth_irq_status_chk.sv
module eth_irq_status_chk
  import eth_irq_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [REG_W-1:0]     reg_wdata,
  input logic                 rx_abort_nomem,
  input logic                 rx_abort_long,
  input logic                 rx_abort_discard,
  input logic                 alloc_req,
  input logic                 alloc_ok,
  input logic                 alloc_fail,
  input logic                 txq_empty_evt,
  input logic                 txc_fifo_empty,
  input logic                 txc_pop,
  input logic [STAT_BITS-1:0] stat
);
  logic ack_wr;
  assign ack_wr = reg_wr && reg_addr == A_STAT;

  // R2
  rxovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_abort_nomem || rx_abort_long || rx_abort_discard) |=> stat[B_RXOVR]);

  // R3
  alloc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((alloc_req || alloc_fail) && !alloc_ok) |=> !stat[B_ALLOC]);

  // R4
  txe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[B_TXE] && !(ack_wr && reg_wdata[B_TXE])) |=> stat[B_TXE]);

  // R5
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txc_pop |-> !txc_fifo_empty);

  // R5
  pop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txc_pop |-> (ack_wr && reg_wdata[B_TX]));

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txq_empty_evt && ack_wr && reg_wdata[B_TXE]) |=> stat[B_TXE]);
endmodule

bind eth_irq_status eth_irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .rx_abort_nomem(rx_abort_nomem),
  .rx_abort_long(rx_abort_long), .rx_abort_discard(rx_abort_discard),
  .alloc_req(alloc_req), .alloc_ok(alloc_ok), .alloc_fail(alloc_fail),
  .txq_empty_evt(txq_empty_evt), .txc_fifo_empty(txc_fifo_empty),
  .txc_pop(txc_pop), .stat(status_w)
);

// File: tb/eth_irq_status_bench.sv
`timescale 1ns/1ps
module eth_irq_status_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic rx_abort_nomem = 0, rx_abort_long = 0, rx_abort_discard = 0;
  logic alloc_req = 0, alloc_ok = 0, alloc_fail = 0, txq_empty_evt = 0;
  logic txc_fifo_empty = 1, rxc_fifo_empty = 1, txc_pop;
  logic link_evt = 0, cnt_roll_evt = 0, tx_fatal_evt = 0;
  logic link_err_en = 1, cnt_reg_rd = 0, tx_en_set = 0, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  eth_irq_status u_eth_irq_status (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_abort_nomem(rx_abort_nomem), .rx_abort_long(rx_abort_long),
    .rx_abort_discard(rx_abort_discard), .alloc_req(alloc_req),
    .alloc_ok(alloc_ok), .alloc_fail(alloc_fail), .txq_empty_evt(txq_empty_evt),
    .txc_fifo_empty(txc_fifo_empty), .txc_pop(txc_pop),
    .rxc_fifo_empty(rxc_fifo_empty), .link_evt(link_evt),
    .cnt_roll_evt(cnt_roll_evt), .tx_fatal_evt(tx_fatal_evt),
    .link_err_en(link_err_en), .cnt_reg_rd(cnt_reg_rd),
    .tx_en_set(tx_en_set), .irq(irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0; reg_addr = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); check("R1/R12 status after reset", v, 8'h00);
    rd(2'd1, v); check("R1 mask after reset", v, 8'h00);
    check("R1 irq after reset", {7'd0, irq}, 8'h00);
    rd(2'd2, v); check("R12 unmapped address", v, 8'h00);
  endtask

  task automatic t_rxovr();
    logic [7:0] v;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      rx_abort_nomem = (k == 0); rx_abort_long = (k == 1); rx_abort_discard = (k == 2);
      @(negedge clk);
      rx_abort_nomem = 0; rx_abort_long = 0; rx_abort_discard = 0;
      rd(2'd0, v); check("R2 overrun set by abort source", v & 8'h10, 8'h10);
      wr(2'd0, 8'hEF);
      rd(2'd0, v); check("R11 zero ack bit keeps overrun", v & 8'h10, 8'h10);
      wr(2'd0, 8'h10);
      rd(2'd0, v); check("R2 overrun cleared by ack", v & 8'h10, 8'h00);
    end
  endtask

  task automatic t_alloc();
    logic [7:0] v;
    @(negedge clk); alloc_ok = 1; @(negedge clk); alloc_ok = 0;
    rd(2'd0, v); check("R3 alloc set on success", v & 8'h08, 8'h08);
    wr(2'd0, 8'h08);
    rd(2'd0, v); check("R3 alloc ignores ack", v & 8'h08, 8'h08);
    @(negedge clk); alloc_req = 1; @(negedge clk); alloc_req = 0;
    rd(2'd0, v); check("R3 alloc cleared by request", v & 8'h08, 8'h00);
    @(negedge clk); alloc_ok = 1; @(negedge clk); alloc_ok = 0;
    @(negedge clk); alloc_fail = 1; @(negedge clk); alloc_fail = 0;
    rd(2'd0, v); check("R3 alloc cleared by failure", v & 8'h08, 8'h00);
  endtask

  task automatic t_txempty();
    logic [7:0] v;
    @(negedge clk); txq_empty_evt = 1; @(negedge clk); txq_empty_evt = 0;
    repeat (5) @(negedge clk);
    rd(2'd0, v); check("R4 tx-empty holds", v & 8'h04, 8'h04);
    wr(2'd0, 8'h04);
    rd(2'd0, v); check("R4 tx-empty cleared by ack", v & 8'h04, 8'h00);
  endtask

  task automatic t_txc();
    logic [7:0] v;
    @(negedge clk); txc_fifo_empty = 0;
    rd(2'd0, v); check("R5 tx bit follows fifo", v & 8'h02, 8'h02);
    @(negedge clk);
    reg_wr = 1; reg_addr = 0; reg_wdata = 8'h02;
    #1 check("R5 pop during ack", {7'd0, txc_pop}, 8'h01);
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0;
    #1 check("R5 pop lasts one cycle", {7'd0, txc_pop}, 8'h00);
    txc_fifo_empty = 1;
    rd(2'd0, v); check("R5 tx bit clears with fifo", v & 8'h02, 8'h00);
    @(negedge clk);
    reg_wr = 1; reg_addr = 0; reg_wdata = 8'h02;
    #1 check("R5 no pop on empty fifo", {7'd0, txc_pop}, 8'h00);
    @(negedge clk); reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic t_rcv();
    logic [7:0] v;
    @(negedge clk); rxc_fifo_empty = 0;
    rd(2'd0, v); check("R6 rcv bit follows fifo", v & 8'h01, 8'h01);
    wr(2'd0, 8'h01);
    rd(2'd0, v); check("R6 rcv ignores ack", v & 8'h01, 8'h01);
    @(negedge clk); rxc_fifo_empty = 1;
    rd(2'd0, v); check("R6 rcv clears on drain", v & 8'h01, 8'h00);
  endtask

  task automatic t_engine();
    logic [7:0] v;
    @(negedge clk); link_evt = 1; @(negedge clk); link_evt = 0;
    rd(2'd0, v); check("R7 engine set by link", v & 8'h20, 8'h20);
    @(negedge clk); cnt_reg_rd = 1; @(negedge clk); cnt_reg_rd = 0;
    @(negedge clk); tx_en_set = 1; @(negedge clk); tx_en_set = 0;
    wr(2'd0, 8'h20);
    rd(2'd0, v); check("R9 mismatched clears and ack ignored", v & 8'h20, 8'h20);
    @(negedge clk); link_err_en = 0; @(negedge clk);
    rd(2'd0, v); check("R7 link cause cleared by enable fall", v & 8'h20, 8'h00);
    link_err_en = 1;
    @(negedge clk); cnt_roll_evt = 1; @(negedge clk); cnt_roll_evt = 0;
    @(negedge clk); tx_en_set = 1; @(negedge clk); tx_en_set = 0;
    rd(2'd0, v); check("R8 rollover kept by tx enable", v & 8'h20, 8'h20);
    @(negedge clk); cnt_reg_rd = 1; @(negedge clk); cnt_reg_rd = 0;
    rd(2'd0, v); check("R8 rollover cleared by counter read", v & 8'h20, 8'h00);
    @(negedge clk); tx_fatal_evt = 1; @(negedge clk); tx_fatal_evt = 0;
    @(negedge clk); link_err_en = 0; @(negedge clk); link_err_en = 1;
    @(negedge clk); cnt_reg_rd = 1; @(negedge clk); cnt_reg_rd = 0;
    rd(2'd0, v); check("R9 fatal kept by other clears", v & 8'h20, 8'h20);
    @(negedge clk); tx_en_set = 1; @(negedge clk); tx_en_set = 0;
    rd(2'd0, v); check("R9 fatal cleared by tx enable", v & 8'h20, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    wr(2'd1, 8'h04);
    rd(2'd1, v); check("R10 mask readback", v, 8'h04);
    check("R10 irq low with masked bit clear", {7'd0, irq}, 8'h00);
    @(negedge clk); txq_empty_evt = 1; @(negedge clk); txq_empty_evt = 0;
    #1 check("R10 irq on enabled bit", {7'd0, irq}, 8'h01);
    wr(2'd1, 8'h00);
    #1 check("R10 irq masked off", {7'd0, irq}, 8'h00);
    wr(2'd1, 8'hFF);
    rd(2'd1, v); check("R10 mask upper bits zero", v, 8'h3F);
    rd(2'd0, v); check("R12 status upper bits zero", v & 8'hC0, 8'h00);
    wr(2'd0, 8'h04);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_setwins();
    logic [7:0] v;
    @(negedge clk);
    reg_wr = 1; reg_addr = 0; reg_wdata = 8'h10; rx_abort_long = 1;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0; rx_abort_long = 0;
    rd(2'd0, v); check("R11 set wins over ack", v & 8'h10, 8'h10);
    wr(2'd0, 8'h10);
    rd(2'd0, v); check("R11 later ack clears", v & 8'h10, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_rxovr();
    t_alloc();
    t_txempty();
    t_txc();
    t_rcv();
    t_engine();
    t_irq();
    t_setwins();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung expected done");
      summary();
      $finish;
    end
  end
endmodule